// File: doc/BRIEF.md
# Paged EEPROM Write-Control Sequencer

This block models, in synchronous logic, the control path of a byte-alterable parallel nonvolatile memory. The host drives active-low chip-enable, write-enable and output-enable strobes together with a 15-bit address and an 8-bit data bus. Each write strobe loads one byte into a page buffer. All bytes of a page must share the upper address bits of the first byte. A window timer restarts with every accepted byte. When the timer runs out, a self-timed programming cycle copies the loaded bytes into a register-array store.

While programming runs, reads do not return stored data. They return a status byte. Its top bit is the inverse of the last byte's top bit, and its next bit flips on every read. Host software uses these two bits to detect when the cycle ends. The window and programming durations are parameters in clock cycles, so a simulation can shorten them. The read bus is modelled as a data output with a separate drive-enable, and an external pad drives the high-impedance state from that enable. The store keeps `2**STORE_W` bytes, indexed by the low address bits.

Top module: `eeprom_page_sequencer`

## Requirements
- R1: A write strobe exists only while `ce_n`=0, `we_n`=0 and `oe_n`=1. Strobes with `oe_n`=0 never load a byte and never start programming.
- R2: The address is taken in the first clock cycle in which the last of `ce_n`/`we_n` is low. The stored data is the `din` value of the last cycle before the first of the two rises.
- R3: The byte offset is `addr[6:0]`, so a page holds up to 128 bytes. Loading the same offset twice keeps the later value.
- R4: A new write strobe that starts at most `WINDOW_CYC` cycles after the previous accepted start joins the page and restarts the window. If `WINDOW_CYC` cycles pass with no new start and no strobe active, programming begins.
- R5: While a page is loading, a strobe whose `addr[14:7]` differs from the first byte's is ignored and does not restart the window.
- R6: Programming lasts `PROG_CYC` cycles. It writes only the loaded offsets of the page into the store. Reads that start after it ends return the new data.
- R7: A read that starts during programming returns status for any address. Bit 7 is the inverse of bit 7 of the last accepted byte, and bits 5..0 are that byte's bits 5..0.
- R8: During programming, status bit 6 is 1 on the first read start after programming begins and inverts on each later read start.
- R9: Write strobes that start during programming are ignored and leave the last-byte value unchanged.
- R10: When `ce_n`=0 and `oe_n`=0, `dout_en` is 1 in the following cycle and `dout` holds the read result. Outside programming that result is the store byte at `addr[STORE_W-1:0]`. Otherwise `dout_en` is 0 and `dout` is 0.
- R11: After reset the block is idle with `dout_en`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or programming status |
| dout_en | output | 1 | Read bus drive enable |

## Verification
The bench probes the window edge from both sides. A byte that starts exactly `WINDOW_CYC` cycles after the previous one must join the page, and one cycle later it must be dropped. A design with an off-by-one timer would either commit early and lose the byte, or accept a strobe during programming and corrupt the last-byte status. Reads placed on the last programming cycle and on the first idle cycle catch a busy period that is too short or too long. A mismatched-page strobe, followed by a status read one cycle after the original expiry, exposes a design that lets such a strobe restart the timer. A write controlled by chip-enable, whose data changes while write-enable rises, exposes capture on the wrong edge. The sequence of status reads shows whether the polling bit is inverted and whether the toggle bit alternates.

// File: rtl/eeprom_page_sequencer.sv
`timescale 1ns/1ps
module eeprom_page_sequencer #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int OFS_W      = 7,
  parameter int STORE_W    = 10,
  parameter int WINDOW_CYC = 12500,
  parameter int PROG_CYC   = 375000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int PAGE_W   = ADDR_W - OFS_W;
  localparam int PAGE_LEN = 1 << OFS_W;
  localparam int WCNT_W   = $clog2(WINDOW_CYC + 1);
  localparam int PCNT_W   = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} state_t;

  state_t              state;
  logic                wr_q, rd_q, wr_ok, tog;
  logic [PAGE_W-1:0]   page_q;
  logic [OFS_W-1:0]    ofs_q;
  logic [DATA_W-1:0]   din_q, last_q, status;
  logic [WCNT_W-1:0]   wcnt;
  logic [PCNT_W-1:0]   pcnt;
  logic [PAGE_LEN-1:0] valid;
  logic [DATA_W-1:0]   latch [PAGE_LEN];
  logic [DATA_W-1:0]   mem   [2**STORE_W];

  wire wr_act   = !ce_n && !we_n && oe_n;
  wire rd_act   = !ce_n && !oe_n;
  wire wr_start = wr_act && !wr_q;
  wire wr_end   = wr_q && !wr_act;
  wire rd_start = rd_act && !rd_q;
  wire page_hit = addr[ADDR_W-1:OFS_W] == page_q;
  wire take     = wr_start && (state == S_IDLE || (state == S_LOAD && page_hit));
  wire expire   = state == S_LOAD && !wr_act && !wr_q && wcnt == WCNT_W'(WINDOW_CYC - 1);

  function automatic logic [STORE_W-1:0] commit_idx(logic [PAGE_W-1:0] pg, int i);
    logic [ADDR_W-1:0] full;
    full = {pg, OFS_W'(i)};
    return full[STORE_W-1:0];
  endfunction

  always_comb begin
    status = last_q;
    status[DATA_W-1] = ~last_q[DATA_W-1];
    status[DATA_W-2] = rd_start ? ~tog : tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      wr_ok  <= 1'b0;
      tog    <= 1'b0;
      page_q <= '0;
      ofs_q  <= '0;
      din_q  <= '0;
      last_q <= '0;
      wcnt   <= '0;
      pcnt   <= '0;
      valid  <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act) din_q <= din;
      if (wr_start) wr_ok <= take;
      if (take) begin
        ofs_q <= addr[OFS_W-1:0];
        wcnt  <= '0;
        if (state == S_IDLE) begin
          page_q <= addr[ADDR_W-1:OFS_W];
          state  <= S_LOAD;
        end
      end else if (state == S_LOAD && wcnt != WCNT_W'(WINDOW_CYC - 1)) begin
        wcnt <= wcnt + 1'b1;
      end
      if (wr_end && wr_ok) begin
        valid[ofs_q] <= 1'b1;
        last_q       <= din_q;
        wr_ok        <= 1'b0;
      end
      if (expire) begin
        state <= S_PROG;
        pcnt  <= '0;
        tog   <= 1'b0;
        valid <= '0;
      end
      if (state == S_PROG) begin
        if (rd_start) tog <= ~tog;
        pcnt <= pcnt + 1'b1;
        if (pcnt == PCNT_W'(PROG_CYC - 1)) state <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_end && wr_ok) latch[ofs_q] <= din_q;
  end

  always_ff @(posedge clk) begin
    if (expire)
      for (int i = 0; i < PAGE_LEN; i++)
        if (valid[i]) mem[commit_idx(page_q, i)] <= latch[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      dout_en <= rd_act;
      if (!rd_act)               dout <= '0;
      else if (state == S_PROG)  dout <= status;
      else                       dout <= mem[addr[STORE_W-1:0]];
    end
  end

  AST_PROG_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_PROG) |-> $past(state == S_LOAD && !wr_act)); // R4
  AST_RESTART_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && $past(state == S_LOAD) && wcnt == '0) |-> $past(take)); // R5
  AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && $past(state == S_LOAD)) |-> $stable(page_q)); // R5
  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state == S_PROG) |-> $past(pcnt) == PCNT_W'(PROG_CYC - 1)); // R6
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && rd_start) |=> tog != $past(tog)); // R8
  AST_LAST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG) |=> $stable(last_q)); // R9
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> (!dout_en && dout == '0)); // R10
endmodule

// File: tb/test_eeprom_page_sequencer.sv
`timescale 1ns/1ps
module test_eeprom_page_sequencer;
  localparam int W = 40;
  localparam int P = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [14:0] a = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;

  int cyc = 0, checks = 0, failures = 0, last_start = 0, s0 = 0, e = 0;
  bit done = 1'b0;

  typedef struct { int due; bit en; logic [7:0] d; string tag; } exp_t;
  exp_t q[$];

  eeprom_page_sequencer #(.STORE_W(10), .WINDOW_CYC(W), .PROG_CYC(P)) i_eeprom_page_sequencer (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(a), .din(din), .dout(dout), .dout_en(dout_en));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(posedge clk);
    #3;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (dout_en !== it.en || dout !== it.d) begin
        failures++;
        $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
                 it.tag, dout_en, dout, it.en, it.d);
      end
    end
  end

  task automatic wr(input logic [14:0] ad, input logic [7:0] d);
    a = ad; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    last_start = cyc + 1;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [14:0] ad, input logic [7:0] d, input string tag);
    a = ad; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    q.push_back('{cyc + 1, 1'b1, d, tag});
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic chk_idle(input string tag);
    q.push_back('{cyc + 1, 1'b0, 8'h00, tag});
    @(negedge clk);
  endtask

  task automatic go(input int edge_no);
    while (cyc + 1 < edge_no) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_idle("R11 reset state");

    // single byte: status polling then data
    wr(15'h0300, 8'h5A);
    e = last_start + W;
    go(e + 1);
    rd(15'h0300, 8'hDA, "R7 R8 first status read");
    rd(15'h0123, 8'h9A, "R7 R8 second status read, other address");
    go(e + P);
    rd(15'h0300, 8'hDA, "R6 status on last busy cycle");
    rd(15'h0300, 8'h5A, "R6 R10 data after programming");

    // multi-byte page, gap exactly W, rewrite, late write ignored
    wr(15'h0200, 8'h11);
    s0 = last_start;
    go(s0 + W);
    wr(15'h0201, 8'hA2);
    wr(15'h0201, 8'h33);
    wr(15'h027F, 8'h7F);
    e = last_start + W;
    go(e + 1);
    wr(15'h0300, 8'h44);
    rd(15'h0200, 8'hFF, "R7 R9 status keeps last page byte");
    go(e + P + 1);
    rd(15'h0200, 8'h11, "R4 R6 first byte on first idle cycle");
    rd(15'h0201, 8'h33, "R3 rewritten offset keeps later value");
    rd(15'h027F, 8'h7F, "R3 offset 127 loaded");
    rd(15'h0300, 8'h5A, "R9 write during programming ignored");
    chk_idle("R10 bus quiet between reads");

    // byte one cycle past the window is dropped
    wr(15'h0080, 8'h21);
    e = last_start + W;
    go(e + 1);
    wr(15'h0081, 8'h99);
    rd(15'h0081, 8'hE1, "R4 R9 late byte not taken");
    go(e + P + 1);
    rd(15'h0080, 8'h21, "R6 committed single byte");

    // mismatched page ignored, no timer restart
    wr(15'h0180, 8'h10);
    s0 = last_start;
    wr(15'h0200, 8'h55);
    e = s0 + W;
    go(e + 1);
    rd(15'h0180, 8'hD0, "R5 programming starts from first byte");
    go(e + P + 1);
    rd(15'h0200, 8'h11, "R5 mismatched byte ignored");
    rd(15'h0180, 8'h10, "R5 page byte committed");

    // chip-enable controlled write, data from the last low cycle
    a = 15'h0000; din = 8'h00; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b1;
    @(negedge clk);
    a = 15'h0010; din = 8'h3C; ce_n = 1'b0;
    last_start = cyc + 1;
    @(negedge clk); @(negedge clk);
    we_n = 1'b1; din = 8'hC3;
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    e = last_start + W;
    go(e + 1);
    rd(15'h0010, 8'hFC, "R2 status from captured byte");
    go(e + P + 1);
    rd(15'h0010, 8'h3C, "R2 address and data capture");

    // strobe with output enable low is not a write
    a = 15'h0010; din = 8'hEE; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    chk_idle("R10 bus quiet after strobe");
    go(cyc + W + 6);
    rd(15'h0010, 8'h3C, "R1 no write or programming with oe low");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule